// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer/counter

An 8-bit counter advances once per clock in which the tick enable is high. A 3-bit mode field selects one of four counting schemes. The first is a plain wrap-around counter. The second restarts after matching compare register A. The third is a single-slope (fast) PWM. The fourth is a dual-slope (phase-correct) PWM that counts up to TOP and back down. TOP is either 0xFF or the active value of compare register A, depending on the mode. BOTTOM is 0x00.

Each of the two compare channels keeps a buffer register, which is what software writes, and an active copy, which is what the counter is compared against. The mode decides whether the active copy follows a write at once or only at a counting boundary. Channel B drives a waveform output pin. A 2-bit output-mode field sets how that pin reacts to matches and to BOTTOM. Three sticky flags record overflow, a match on A and a match on B.

A small register port gives access to the settings. A write takes effect at the clock edge. A read is combinational from the address.

| Address | Contents |
|---------|----------|
| 0 | Control: mode in bits [2:0], output mode in bits [5:4]. Bits 3, 6 and 7 read 0. |
| 1 | Counter value. |
| 2 | Buffer of compare register A. |
| 3 | Buffer of compare register B. |
| 4 | Flags: bit 0 overflow, bit 1 match A, bit 2 match B. |
| 5 to 7 | Read as 0. |

Top module: `pwm_timer8`

## Requirements
- R1: After reset, every register reads 0x00, and the wave output, its enable and all flags are 0. A read of addresses 5 to 7 returns 0. After a write of 0xFF to address 0, that address reads back 0x37, because bits 3, 6 and 7 always read 0.
- R2: In mode 0 the counter rises by one on each tick and wraps from 0xFF to 0x00. A tick taken while the count is 0xFF sets flag bit 0.
- R3: In modes 1 and 5 (TOP is 0xFF in mode 1 and A in mode 5) the counter climbs from 0 to TOP and then falls back to 0. TOP and 0 each last exactly one tick. A tick taken at 0 sets flag bit 0.
- R4: In mode 2 the counter returns to 0 on the tick after it equals A. Flag bit 0 is set only by a tick taken at 0xFF.
- R5: In mode 3 (TOP is 0xFF) and in mode 7 (TOP is A) the counter returns to 0 on the tick after TOP. Flag bit 0 is set by a tick at 0xFF in mode 3 and by a tick at TOP in mode 7.
- R6: Writes to addresses 2 and 3 always land in the buffer, and a read returns the buffer. The active copy follows the buffer at once in modes 0, 2, 4 and 6. In modes 1 and 5 it loads on a tick taken at TOP. In modes 3 and 7 it loads on a tick taken at 0.
- R7: A tick with the count equal to active A sets flag bit 1. A tick with the count equal to active B sets flag bit 2. Writing a 1 to a flag bit clears it. A set and a clear in the same cycle leave the flag set.
- R8: In modes 3 and 7, output mode 10 makes the wave go low on a B match and high on a tick at 0 that is not also a match. Output mode 11 does the reverse.
- R9: In modes 1 and 5, a B match while counting up drives the wave to 0 under output mode 10 and to 1 under output mode 11. A B match while counting down drives the opposite level.
- R10: In modes 1 and 5, when active B equals TOP and output-mode bit 1 is set, the wave is driven to output-mode bit 0 on every tick.
- R11: In modes 0 and 2, output modes 10 and 11 make the wave toggle on each B match.
- R12: The wave enable equals output-mode bit 1. Under output modes 00 and 01 the wave keeps its level.
- R13: Modes 4 and 6 freeze the counter, the flags and the wave while ticks arrive.
- R14: A write to address 1 loads the counter and wins over a tick in the same cycle. The counting direction is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable, one clock wide per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| wave_b | output | 1 | Channel B waveform |
| wave_b_en | output | 1 | High when the waveform drives the pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_a_flag | output | 1 | Sticky compare A flag |
| match_b_flag | output | 1 | Sticky compare B flag |

## Verification
The hardest situation to reach from the ports is a buffered compare change that lands on a boundary of the dual-slope count. A matching example is active B becoming equal to TOP, or TOP itself moving while the counter is past it. The stimulus first rewrites a buffer in an immediate mode. It then switches to a dual-slope or single-slope mode and rewrites A and B in the middle of a run, so that loads occur at TOP and at 0 at arbitrary counter phases. Sparse ticks (one every two clocks) keep writes, flag clears and tick events overlapping. The reference model follows every register and output on every clock.

// File: rtl/pwm_timer8_pkg.sv
// Package pwm_timer8_pkg
// Holds the mode encoding shared by the timer modules, plus helpers that
// classify a mode value. It assumes the mode field is always 3 bits wide.
package pwm_timer8_pkg;

    typedef enum logic [2:0] {
        MD_FREE      = 3'd0,
        MD_PC_FULL   = 3'd1,
        MD_CLR_CMP   = 3'd2,
        MD_FAST_FULL = 3'd3,
        MD_RSV4      = 3'd4,
        MD_PC_CMPA   = 3'd5,
        MD_RSV6      = 3'd6,
        MD_FAST_CMPA = 3'd7
    } tmode_e;

    // dual-slope modes
    function automatic logic mode_is_pc(input logic [2:0] m);
        return (m == MD_PC_FULL) || (m == MD_PC_CMPA);
    endfunction

    // single-slope PWM modes
    function automatic logic mode_is_fast(input logic [2:0] m);
        return (m == MD_FAST_FULL) || (m == MD_FAST_CMPA);
    endfunction

    // reserved codes freeze the block
    function automatic logic mode_is_rsv(input logic [2:0] m);
        return (m == MD_RSV4) || (m == MD_RSV6);
    endfunction

    // modes whose TOP is the active compare A value
    function automatic logic mode_top_a(input logic [2:0] m);
        return (m == MD_CLR_CMP) || (m == MD_PC_CMPA) || (m == MD_FAST_CMPA);
    endfunction

endpackage

// File: rtl/pwm_timer8_count.sv
// Module pwm_timer8_count
// The counter and its direction flop. Outside the dual-slope modes it wraps
// to zero after TOP. In the dual-slope modes it turns around at TOP and at
// zero, holding each for one tick. A load wins over a tick. It assumes the
// tick input is already gated off in the reserved modes.
module pwm_timer8_count
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] top,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_up
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // advance, turn around or load the counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            cnt_up <= 1'b1;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (tick) begin
            if (mode_is_pc(mode)) begin
                if (cnt_up) begin
                    if (cnt >= top) begin
                        if (cnt != '0) begin
                            cnt    <= cnt - ONE;
                            cnt_up <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end else if (cnt == '0) begin
                    cnt_up <= 1'b1;
                    if (top != '0) cnt <= ONE;
                end else begin
                    cnt <= cnt - ONE;
                end
            end else begin
                cnt <= (cnt == top) ? '0 : cnt + ONE;
            end
        end
    end

    assert_load_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && mode_is_pc(mode) && cnt != '0 && cnt < top)
        |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/pwm_timer8_cmpbuf.sv
// Module pwm_timer8_cmpbuf
// One compare channel: a buffer that the register port writes, and the
// active copy used for matching. In immediate modes the active copy takes a
// write at once and otherwise tracks the buffer. In buffered modes it copies
// the buffer only when load is high.
module pwm_timer8_cmpbuf #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             immediate,
    input  logic             load,
    output logic [CNT_W-1:0] buf_q,
    output logic [CNT_W-1:0] act_q
);

    // hold the software-written value
    always_ff @(posedge clk) begin
        if (!rst_n)  buf_q <= '0;
        else if (wr) buf_q <= wdata;
    end

    // move the value into the active copy
    always_ff @(posedge clk) begin
        if (!rst_n)                 act_q <= '0;
        else if (wr && immediate)   act_q <= wdata;
        else if (immediate || load) act_q <= buf_q;
    end

    assert_imm_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && immediate) |=> act_q == $past(wdata));

    assert_buf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!immediate && !load) |=> $stable(act_q));

endmodule

// File: rtl/pwm_timer8_wave.sv
// Module pwm_timer8_wave
// Channel B waveform register. It applies the action that the mode and the
// output-mode field select on each tick. The action may depend on a match, on
// zero, on the counting direction, or on compare equal to TOP. It assumes the
// tick input is already gated off in the reserved modes.
module pwm_timer8_wave
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       mode,
    input  logic [1:0]       omode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_up,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] top,
    output logic             wave
);

    logic wave_nxt;
    logic hit;

    assign hit = (cnt == cmp);

    // choose the next level from the mode and the event
    always_comb begin
        wave_nxt = wave;
        if (tick && omode[1]) begin
            if (mode_is_pc(mode)) begin
                if (cmp == top)  wave_nxt = omode[0];
                else if (hit)    wave_nxt = cnt_up ? omode[0] : ~omode[0];
            end else if (mode_is_fast(mode)) begin
                if (hit)             wave_nxt = omode[0];
                else if (cnt == '0)  wave_nxt = ~omode[0];
            end else if (hit) begin
                wave_nxt = ~wave;
            end
        end
    end

    // register the waveform
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= wave_nxt;
    end

    assert_top_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_is_pc(mode) && omode[1] && cmp == top) |=> wave == $past(omode[0]));

    assert_disc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !omode[1] |=> $stable(wave));

endmodule

// File: rtl/pwm_timer8.sv
// Module pwm_timer8
// Top of the timer. It holds the control and flag registers and the register
// port, derives TOP and the compare-load strobe, and instantiates the counter,
// two compare channels and the waveform stage. It assumes CNT_W >= 6, so that
// the control fields fit in one data word.
module pwm_timer8
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              wave_b,
    output logic              wave_b_en,
    output logic              ovf_flag,
    output logic              match_a_flag,
    output logic              match_b_flag
);

    localparam int NCH = 2;
    localparam logic [CNT_W-1:0]  MAXV     = {CNT_W{1'b1}};
    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(1);
    localparam int                AD_CMP0  = 2;
    localparam logic [ADDR_W-1:0] AD_FLAGS = ADDR_W'(4);

    logic [2:0]       mode_q;
    logic [1:0]       om_q;
    logic [2:0]       flags_q;
    logic [CNT_W-1:0] cnt;
    logic             cnt_up;
    logic [CNT_W-1:0] top;
    logic             tick_ok;
    logic             is_pc;
    logic             is_fast;
    logic             cmp_ld;
    logic             ovf_hit;
    logic [CNT_W-1:0] cmp_buf [NCH];
    logic [CNT_W-1:0] cmp_act [NCH];

    assign is_pc   = mode_is_pc(mode_q);
    assign is_fast = mode_is_fast(mode_q);
    assign tick_ok = tick_en && !mode_is_rsv(mode_q);
    assign top     = mode_top_a(mode_q) ? cmp_act[0] : MAXV;
    assign cmp_ld  = tick_ok && ((is_pc && cnt == top) || (is_fast && cnt == '0));
    assign ovf_hit = tick_ok && (is_pc ? (cnt == '0)
                             : (mode_q == MD_FAST_CMPA) ? (cnt == top) : (cnt == MAXV));

    // control register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            om_q   <= '0;
        end else if (reg_wr && reg_addr == AD_CTRL) begin
            mode_q <= reg_wdata[2:0];
            om_q   <= reg_wdata[5:4];
        end
    end

    // sticky flags: write-one clears, a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~((reg_wr && reg_addr == AD_FLAGS) ? reg_wdata[2:0] : 3'b000))
                     | {tick_ok && cnt == cmp_act[1], tick_ok && cnt == cmp_act[0], ovf_hit};
        end
    end

    pwm_timer8_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_ok),
        .mode   (mode_q),
        .top    (top),
        .ld     (reg_wr && reg_addr == AD_COUNT),
        .ld_val (reg_wdata),
        .cnt    (cnt),
        .cnt_up (cnt_up)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_timer8_cmpbuf #(.CNT_W(CNT_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (reg_wr && reg_addr == ADDR_W'(AD_CMP0 + c)),
            .wdata     (reg_wdata),
            .immediate (!is_pc && !is_fast),
            .load      (cmp_ld),
            .buf_q     (cmp_buf[c]),
            .act_q     (cmp_act[c])
        );
    end

    pwm_timer8_wave #(.CNT_W(CNT_W)) u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_ok),
        .mode   (mode_q),
        .omode  (om_q),
        .cnt    (cnt),
        .cnt_up (cnt_up),
        .cmp    (cmp_act[1]),
        .top    (top),
        .wave   (wave_b)
    );

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AD_CTRL)       reg_rdata = CNT_W'({2'b00, om_q, 1'b0, mode_q});
        else if (reg_addr == AD_COUNT) reg_rdata = cnt;
        else if (reg_addr == ADDR_W'(AD_CMP0))     reg_rdata = cmp_buf[0];
        else if (reg_addr == ADDR_W'(AD_CMP0 + 1)) reg_rdata = cmp_buf[1];
        else if (reg_addr == AD_FLAGS) reg_rdata = CNT_W'(flags_q);
    end

    assign wave_b_en    = om_q[1];
    assign ovf_flag     = flags_q[0];
    assign match_a_flag = flags_q[1];
    assign match_b_flag = flags_q[2];

    assert_match_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && cnt == cmp_act[0]) |=> match_a_flag);

    assert_rsv_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_is_rsv(mode_q) && !(reg_wr && reg_addr == AD_COUNT)) |=> $stable(cnt));

    assert_free_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && mode_q == MD_FREE && !reg_wr) |=> cnt == $past(cnt) + CNT_W'(1));

endmodule

// File: tb/pwm_timer8_bench.sv
module pwm_timer8_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       wave_b, wave_b_en, ovf_flag, match_a_flag, match_b_flag;

    always #10 clk = ~clk;

    pwm_timer8 u_pwm_timer8 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wave_b(wave_b), .wave_b_en(wave_b_en), .ovf_flag(ovf_flag),
        .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
    );

    int total = 0, bad = 0, cyc = 0, tdiv = 0, fix_addr = -1;
    bit req = 0, chk_on = 0;
    int req_a, req_d;
    string cur_req = "R1";

    // stimulus driver, just after each rising edge
    always @(posedge clk) begin
        #2;
        cyc++;
        tick_en = (tdiv != 0) && (cyc % tdiv == 0);
        if (req) begin
            reg_wr = 1'b1; reg_addr = 3'(req_a); reg_wdata = 8'(req_d); req = 0;
        end else begin
            reg_wr = 1'b0;
            reg_addr = (fix_addr >= 0) ? 3'(fix_addr) : 3'(cyc % 8);
        end
    end

    // behavioural reference model
    int m_cnt, m_up, m_bufA, m_bufB, m_actA, m_actB, m_mode, m_om, m_fl, m_wave;
    int t_top, t_fl, t_wave, t_cnt, t_up, t_actA, t_actB, t_o1, t_o0;
    bit t_pc, t_fast, t_imm, t_tk, t_ld;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_bufA = 0; m_bufB = 0; m_actA = 0; m_actB = 0;
            m_mode = 0; m_om = 0; m_fl = 0; m_wave = 0;
        end else begin
            t_pc   = (m_mode == 1 || m_mode == 5);
            t_fast = (m_mode == 3 || m_mode == 7);
            t_imm  = !t_pc && !t_fast;
            t_tk   = tick_en && !(m_mode == 4 || m_mode == 6);
            t_top  = (m_mode == 2 || m_mode == 5 || m_mode == 7) ? m_actA : 255;
            t_o1   = (m_om >> 1) & 1;
            t_o0   = m_om & 1;
            t_fl   = m_fl;
            if (reg_wr && reg_addr == 4) t_fl = t_fl & ~(int'(reg_wdata) & 7);
            if (t_tk) begin
                if (t_pc ? (m_cnt == 0) : (m_mode == 7 ? m_cnt == t_top : m_cnt == 255)) t_fl |= 1;
                if (m_cnt == m_actA) t_fl |= 2;
                if (m_cnt == m_actB) t_fl |= 4;
            end
            t_wave = m_wave;
            if (t_tk && t_o1 == 1) begin
                if (t_pc) begin
                    if (m_actB == t_top) t_wave = t_o0;
                    else if (m_cnt == m_actB) t_wave = m_up ? t_o0 : 1 - t_o0;
                end else if (t_fast) begin
                    if (m_cnt == m_actB) t_wave = t_o0;
                    else if (m_cnt == 0) t_wave = 1 - t_o0;
                end else if (m_cnt == m_actB) t_wave = 1 - m_wave;
            end
            t_cnt = m_cnt; t_up = m_up;
            if (t_tk) begin
                if (t_pc) begin
                    if (m_up == 1) begin
                        if (m_cnt >= t_top) begin
                            if (m_cnt != 0) begin t_cnt = m_cnt - 1; t_up = 0; end
                        end else t_cnt = m_cnt + 1;
                    end else if (m_cnt == 0) begin
                        t_up = 1; t_cnt = (t_top == 0) ? 0 : 1;
                    end else t_cnt = m_cnt - 1;
                end else t_cnt = (m_cnt == t_top) ? 0 : (m_cnt + 1) % 256;
            end
            if (reg_wr && reg_addr == 1) t_cnt = reg_wdata;
            t_ld = t_tk && ((t_pc && m_cnt == t_top) || (t_fast && m_cnt == 0));
            t_actA = (t_imm || t_ld) ? m_bufA : m_actA;
            t_actB = (t_imm || t_ld) ? m_bufB : m_actB;
            if (reg_wr && reg_addr == 2) begin m_bufA = reg_wdata; if (t_imm) t_actA = reg_wdata; end
            if (reg_wr && reg_addr == 3) begin m_bufB = reg_wdata; if (t_imm) t_actB = reg_wdata; end
            if (reg_wr && reg_addr == 0) begin m_mode = reg_wdata & 7; m_om = (reg_wdata >> 4) & 3; end
            m_cnt = t_cnt; m_up = t_up; m_actA = t_actA; m_actB = t_actB;
            m_fl = t_fl; m_wave = t_wave;
        end
    end

    // compare outputs with the model at every falling edge
    int e_rd;
    always @(negedge clk) begin
        if (chk_on) begin
            case (reg_addr)
                3'd0: e_rd = (m_om << 4) | m_mode;
                3'd1: e_rd = m_cnt;
                3'd2: e_rd = m_bufA;
                3'd3: e_rd = m_bufB;
                3'd4: e_rd = m_fl;
                default: e_rd = 0;
            endcase
            total++;
            if (int'(reg_rdata) != e_rd || int'(wave_b) != m_wave || int'(wave_b_en) != (m_om >> 1)
                || int'({match_b_flag, match_a_flag, ovf_flag}) != m_fl) begin
                bad++;
                $display("FAIL %s cyc=%0d addr=%0d rdata=%h exp=%h wave=%b exp=%0d en=%b exp=%0d flags=%b exp=%0d",
                         cur_req, cyc, reg_addr, reg_rdata, e_rd, wave_b, m_wave, wave_b_en,
                         m_om >> 1, {match_b_flag, match_a_flag, ovf_flag}, m_fl);
            end
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        req_a = a; req_d = d; req = 1;
        wait (req == 0);
        @(posedge clk);
    endtask

    task automatic run(input int n, input string r);
        cur_req = r;
        repeat (n) @(posedge clk);
    endtask

    int exp_seq[9] = '{2, 3, 4, 3, 2, 1, 0, 1, 2};
    bit seen;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #5 chk_on = 1;
        // R1: reset values at every address
        for (int a = 0; a < 8; a++) begin
            fix_addr = a;
            @(posedge clk); #5;
            chk("R1", reg_rdata, 0);
            chk("R1", {wave_b, wave_b_en, ovf_flag, match_a_flag, match_b_flag}, 0);
        end
        wr(0, 8'hFF);
        fix_addr = 0;
        @(posedge clk); #5 chk("R1", reg_rdata, 8'h37);
        wr(0, 0);
        // R3: explicit dual-slope sequence with TOP = A = 4
        wr(2, 4);
        wr(0, 5);
        fix_addr = 1; tdiv = 1; cur_req = "R3";
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (reg_rdata == 8'd1) seen = 1;
        end
        chk("R3", seen, 1);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk("R3", reg_rdata, exp_seq[i]);
        end
        tdiv = 0; fix_addr = -1;
        wr(0, 0);
        // R2, R11: free counting with toggle on B
        wr(1, 0); wr(3, 8'h40); wr(0, 8'h20); tdiv = 1;
        run(300, "R2"); run(300, "R11");
        // R7: flag clears racing new events
        for (int i = 0; i < 20; i++) begin wr(4, 7); run(7, "R7"); end
        wr(4, 2); run(40, "R7");
        // R4, R6: clear on compare with immediate rewrites
        wr(0, 8'h22); wr(2, 8'h30); run(200, "R4");
        wr(2, 8'h20); run(200, "R6");
        wr(2, 8'hFF); run(600, "R4");
        // R8, R5: single-slope PWM
        wr(3, 8'h80); wr(0, 8'h23); run(700, "R8");
        wr(0, 8'h33); run(600, "R8");
        wr(2, 8'h50); wr(3, 8'h20); wr(0, 8'h27); run(300, "R5");
        wr(2, 8'h60); run(300, "R6");
        wr(3, 8'h50); run(300, "R8");
        wr(3, 0); run(200, "R8");
        // R9: dual-slope actions, sparse ticks
        wr(3, 8'h40); wr(0, 8'h21); tdiv = 2; run(1200, "R9");
        wr(0, 8'h31); run(1100, "R9");
        wr(2, 8'h30); wr(3, 8'h10); wr(0, 8'h25); run(300, "R3");
        wr(3, 8'h18); run(300, "R6");
        // R10: compare B equal to TOP
        wr(3, 8'h30); run(300, "R10");
        wr(0, 8'h35); run(300, "R10");
        wr(3, 8'hFF); wr(0, 8'h31); run(1100, "R10");
        // R12: disconnected and reserved output modes
        wr(0, 8'h01); run(200, "R12");
        wr(0, 8'h11); run(200, "R12");
        // R13: reserved modes freeze
        wr(0, 8'h34); run(100, "R13");
        wr(0, 8'h36); wr(1, 8'h10); run(100, "R13");
        // R14: counter loads against ticks
        wr(0, 8'h20); tdiv = 1;
        for (int i = 0; i < 10; i++) begin wr(1, 8'hF0 + i); run(5, "R14"); end
        wr(1, 8'hFE); run(20, "R2");
        wr(0, 8'h21); wr(1, 8'h80); run(600, "R14");
        tdiv = 0; run(4, "R1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule